// File: doc/BRIEF.md
# Wormhole Mesh Router with Vertical-First Routing

This block is a five-port router for a partial two-dimensional mesh. Its ports face the local node and the north, south, east and west neighbours. Each flit is one link word. It enters a per-port input FIFO and crosses a crossbar to the output picked by deterministic dimension-ordered routing: the vertical dimension is resolved first and the horizontal one second. Switching is wormhole. A head flit claims an output, and the body and tail flits of the same packet follow it through that output without interruption.

Back-pressure between neighbours uses credits. On the receive side, the upstream sender may push a flit only while it holds a credit for this router's input FIFO. The router returns one credit pulse for every flit that leaves that FIFO. On the transmit side, the router keeps one credit counter per output. The counter starts at the downstream buffer depth. A flit may leave only while the counter is above zero, and each returned credit pulse adds one. The no-load hop latency has an extra-cycle parameter so that designers can explore how sensitive the network is to latency.

Top module: `mesh_router`

## Requirements
- R1: Port numbering is local=0, north=1, south=2, east=3, west=4. A head flit carries its destination X in bits [COORD_W-1:0] and its destination Y in bits [2*COORD_W-1:COORD_W]. If Y is below MY_Y the flit goes north. If Y is above MY_Y it goes south. If Y equals MY_Y it goes east when X is above MY_X, west when X is below MY_X, and local when X equals MY_X.
- R2: With no contention and credits available, a flit sampled on an input at clock edge k appears on its output in the cycle after edge k+1+HOP_LAT.
- R3: Each input buffers up to DEPTH flits and forwards them in arrival order. A correct sender never overflows the buffer.
- R4: `rx_credit[p]` pulses for one cycle, in the cycle after each flit leaves input FIFO p, with exactly one pulse per flit.
- R5: Each output holds a credit counter that starts at DEPTH, drops by one per forwarded flit and rises by one per `tx_credit` pulse. No flit leaves while the counter is zero.
- R6: An output accepted a head flit without tail is held by that input until the tail flit passes; no flit of another packet appears on it in between.
- R7: When several inputs contend for a free output, grants rotate round-robin. An input that has just won cannot win again in the next cycle while another contender is waiting.
- R8: During and right after reset, `tx_valid` and `rx_credit` are all zero.
- R9: Flits bound for different outputs cross the crossbar in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 5 | Flit present on each input link |
| rx_data | input | 5 x FLIT_W | Flit word per input link |
| rx_head | input | 5 | Flit opens a packet |
| rx_tail | input | 5 | Flit closes a packet |
| rx_credit | output | 5 | Credit pulse back to each upstream sender |
| tx_valid | output | 5 | Flit present on each output link |
| tx_data | output | 5 x FLIT_W | Flit word per output link |
| tx_head | output | 5 | Output flit opens a packet |
| tx_tail | output | 5 | Output flit closes a packet |
| tx_credit | input | 5 | Credit pulse from each downstream receiver |

## Verification
Some checks run on every cycle. The input FIFOs must never overflow or underflow. Each output credit counter must stay within its bound. Every output link must keep packets unbroken (a body flit only inside an open packet, never a head inside one). An arbiter must never grant the same input twice in a row while a rival waits. Other behaviour shows only in the bench's scenarios. These cover the direction picked for each destination, the exact hop latency, arrival order, the count of credits handed back upstream, the stall and resume when downstream credits run dry, and the parallel use of distinct outputs.

// File: rtl/router_pkg.sv
`timescale 1ns/1ps
package router_pkg;
  localparam int NPORT      = 5;
  localparam int PORT_LOCAL = 0;
  localparam int PORT_NORTH = 1;
  localparam int PORT_SOUTH = 2;
  localparam int PORT_EAST  = 3;
  localparam int PORT_WEST  = 4;
endpackage

// File: rtl/flit_fifo.sv
`timescale 1ns/1ps
module flit_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R3
endmodule

// File: rtl/router_inport.sv
`timescale 1ns/1ps
module router_inport import router_pkg::*; #(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 2,
  parameter int DEPTH   = 5,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_head,
  input  logic              in_tail,
  input  logic              pop,
  output logic              q_valid,
  output logic [FLIT_W-1:0] q_data,
  output logic              q_head,
  output logic              q_tail,
  output logic [NPORT-1:0]  q_route,
  output logic              credit_ret
);
  localparam logic [COORD_W-1:0] MXC = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] MYC = COORD_W'(MY_Y);

  logic [FLIT_W+1:0]  front;
  logic               empty;
  logic [NPORT-1:0]   route_now, route_q;
  logic [COORD_W-1:0] dx, dy;

  flit_fifo #(.WIDTH(FLIT_W + 2), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid),
    .din   ({in_head, in_tail, in_data}),
    .pop   (pop),
    .dout  (front),
    .empty (empty)
  );

  assign q_valid = !empty;
  assign q_head  = front[FLIT_W+1];
  assign q_tail  = front[FLIT_W];
  assign q_data  = front[FLIT_W-1:0];
  assign dx      = q_data[COORD_W-1:0];
  assign dy      = q_data[2*COORD_W-1:COORD_W];

  // vertical dimension resolved before horizontal
  always_comb begin
    route_now = '0;
    if (dy < MYC)      route_now[PORT_NORTH] = 1'b1;
    else if (dy > MYC) route_now[PORT_SOUTH] = 1'b1;
    else if (dx > MXC) route_now[PORT_EAST]  = 1'b1;
    else if (dx < MXC) route_now[PORT_WEST]  = 1'b1;
    else               route_now[PORT_LOCAL] = 1'b1;
  end

  assign q_route = q_head ? route_now : route_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q    <= '0;
      credit_ret <= 1'b0;
    end else begin
      credit_ret <= pop;
      if (pop && q_head) route_q <= route_now;
    end
  end
endmodule

// File: rtl/rr_arbiter.sv
`timescale 1ns/1ps
module rr_arbiter #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win;
  logic          found;
  int            idx;

  always_comb begin
    gnt   = '0;
    win   = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        win      = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (advance && found) ptr_q <= IW'((int'(win) + 1) % N);
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R7
  AST_RR_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && $past(advance) && (gnt != '0) && (gnt == $past(gnt)))
      |-> ((req & ~gnt) == '0)); // R7
endmodule

// File: rtl/mesh_router.sv
`timescale 1ns/1ps
module mesh_router import router_pkg::*; #(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 2,
  parameter int DEPTH   = 5,
  parameter int HOP_LAT = 1,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             rx_valid,
  input  logic [NPORT-1:0][FLIT_W-1:0] rx_data,
  input  logic [NPORT-1:0]             rx_head,
  input  logic [NPORT-1:0]             rx_tail,
  output logic [NPORT-1:0]             rx_credit,
  output logic [NPORT-1:0]             tx_valid,
  output logic [NPORT-1:0][FLIT_W-1:0] tx_data,
  output logic [NPORT-1:0]             tx_head,
  output logic [NPORT-1:0]             tx_tail,
  input  logic [NPORT-1:0]             tx_credit
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PKW = FLIT_W + 2;

  logic [NPORT-1:0]  q_valid, q_head, q_tail, pop;
  logic [FLIT_W-1:0] q_data  [NPORT];
  logic [NPORT-1:0]  q_route [NPORT];
  logic [NPORT-1:0]  gnt_m   [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    router_inport #(
      .FLIT_W(FLIT_W), .COORD_W(COORD_W), .DEPTH(DEPTH),
      .MY_X(MY_X), .MY_Y(MY_Y)
    ) u_in (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (rx_valid[i]),
      .in_data    (rx_data[i]),
      .in_head    (rx_head[i]),
      .in_tail    (rx_tail[i]),
      .pop        (pop[i]),
      .q_valid    (q_valid[i]),
      .q_data     (q_data[i]),
      .q_head     (q_head[i]),
      .q_tail     (q_tail[i]),
      .q_route    (q_route[i]),
      .credit_ret (rx_credit[i])
    );
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NPORT; o++) pop = pop | gnt_m[o];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [NPORT-1:0] want, arb_req, owner_q;
    logic             lock_q, fire, open_q;
    logic [CW-1:0]    cred_q;
    logic [PKW-1:0]   sel;
    logic [HOP_LAT:0] sv;
    logic [PKW-1:0]   sd [HOP_LAT+1];

    always_comb begin
      want = '0;
      for (int i = 0; i < NPORT; i++) want[i] = q_valid[i] & q_route[i][o];
      if (cred_q == '0)  arb_req = '0;
      else if (lock_q)   arb_req = want & owner_q;
      else               arb_req = want & q_head;
    end

    rr_arbiter #(.N(NPORT)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (arb_req),
      .advance (!lock_q),
      .gnt     (gnt_m[o])
    );

    assign fire = |gnt_m[o];

    always_comb begin
      sel = '0;
      for (int i = 0; i < NPORT; i++)
        if (gnt_m[o][i]) sel = sel | {q_head[i], q_tail[i], q_data[i]};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lock_q  <= 1'b0;
        owner_q <= '0;
        cred_q  <= CW'(DEPTH);
        sv      <= '0;
      end else begin
        cred_q <= cred_q + CW'(tx_credit[o]) - CW'(fire);
        if (fire) begin
          if (sel[PKW-2])      lock_q <= 1'b0;
          else if (sel[PKW-1]) begin
            lock_q  <= 1'b1;
            owner_q <= gnt_m[o];
          end
        end
        sv[0] <= fire;
        for (int s = 1; s <= HOP_LAT; s++) sv[s] <= sv[s-1];
      end
    end

    always_ff @(posedge clk) begin
      sd[0] <= sel;
      for (int s = 1; s <= HOP_LAT; s++) sd[s] <= sd[s-1];
    end

    assign tx_valid[o] = sv[HOP_LAT];
    assign tx_head[o]  = sd[HOP_LAT][PKW-1];
    assign tx_tail[o]  = sd[HOP_LAT][PKW-2];
    assign tx_data[o]  = sd[HOP_LAT][FLIT_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) open_q <= 1'b0;
      else if (tx_valid[o]) begin
        if (tx_tail[o])      open_q <= 1'b0;
        else if (tx_head[o]) open_q <= 1'b1;
      end
    end

    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cred_q <= CW'(DEPTH)); // R5
    AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[o] && open_q) |-> !tx_head[o]); // R6
    AST_BODY_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[o] && !open_q) |-> tx_head[o]); // R6
  end
endmodule

// File: tb/tb_mesh_router.sv
`timescale 1ns/1ps
module tb_mesh_router;
  localparam int FW = 16;
  localparam int NP = 5;
  localparam int HL = 1;
  localparam int DEP = 5;
  // {input port, dest x, dest y, expected output port}
  localparam int VEC [9][4] = '{
    '{0, 1, 0, 1}, '{0, 1, 3, 2}, '{0, 3, 1, 3}, '{0, 0, 1, 4},
    '{1, 1, 1, 0}, '{4, 3, 3, 2}, '{3, 0, 0, 1}, '{4, 2, 1, 3},
    '{3, 0, 1, 4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]         rx_valid = '0, rx_head = '0, rx_tail = '0;
  logic [NP-1:0][FW-1:0] rx_data = '0;
  logic [NP-1:0]         rx_credit, tx_valid, tx_head, tx_tail, tx_credit;
  logic [NP-1:0][FW-1:0] tx_data;
  logic [NP-1:0]         auto_cr = '0;
  logic [NP-1:0]         give_cr = '0;
  logic                  auto_en = 1'b1;
  assign tx_credit = auto_cr | give_cr;

  mesh_router #(.FLIT_W(FW), .COORD_W(2), .DEPTH(DEP), .HOP_LAT(HL),
                .MY_X(1), .MY_Y(1)) dut (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_head(rx_head),
    .rx_tail(rx_tail), .rx_credit(rx_credit),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_head(tx_head),
    .tx_tail(tx_tail), .tx_credit(tx_credit)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          rcnt [NP] = '{default: 0};
  int          ccnt [NP] = '{default: 0};
  logic [FW-1:0] rdat [NP][256];
  int          rcyc [NP][256];

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (rst_n && tx_valid[p]) begin
        rdat[p][rcnt[p] % 256] = tx_data[p];
        rcyc[p][rcnt[p] % 256] = cyc;
        rcnt[p] = rcnt[p] + 1;
        auto_cr[p] <= auto_en;
      end else begin
        auto_cr[p] <= 1'b0;
      end
      if (rst_n && rx_credit[p]) ccnt[p] = ccnt[p] + 1;
    end
  end

  int nchk = 0;
  int nfail = 0;
  int base [NP];
  int cbase [NP];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input int tag, input int x, input int y);
    return {4'(tag), 8'h5A, 2'(y), 2'(x)};
  endfunction

  task automatic put(input int p, input logic [FW-1:0] d, input logic h, input logic t);
    rx_valid[p] = 1'b1;
    rx_data[p]  = d;
    rx_head[p]  = h;
    rx_tail[p]  = t;
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
    rx_valid = '0;
    rx_head  = '0;
    rx_tail  = '0;
  endtask

  task automatic snap();
    for (int p = 0; p < NP; p++) begin
      base[p]  = rcnt[p];
      cbase[p] = ccnt[p];
    end
  endtask

  function automatic logic [3:0] tag_of(input int p, input int k);
    return rdat[p][(base[p] + k) % 256][15:12];
  endfunction

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail + 1);
    $finish;
  end

  initial begin
    int c0, ex, oth, t;
    repeat (3) @(negedge clk);
    #2;
    chk(tx_valid == '0, "R8 tx_valid in reset", int'(tx_valid), 0);
    chk(rx_credit == '0, "R8 rx_credit in reset", int'(rx_credit), 0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk(tx_valid == '0 && rx_credit == '0, "R8 idle after reset",
        int'({tx_valid, rx_credit}), 0);

    // table walk: routing direction, data and hop latency
    for (int v = 0; v < 9; v++) begin
      snap();
      c0 = cyc;
      ex = VEC[v][3];
      put(VEC[v][0], mk(v, VEC[v][1], VEC[v][2]), 1'b1, 1'b1);
      tick();
      repeat (6) tick();
      oth = 0;
      for (int p = 0; p < NP; p++) if (p != ex) oth += rcnt[p] - base[p];
      chk(rcnt[ex] - base[ex] == 1, "R1 flit on routed port", rcnt[ex] - base[ex], 1);
      chk(oth == 0, "R1 no flit on other ports", oth, 0);
      chk(rdat[ex][base[ex] % 256] == mk(v, VEC[v][1], VEC[v][2]), "R1 flit data",
          int'(rdat[ex][base[ex] % 256]), int'(mk(v, VEC[v][1], VEC[v][2])));
      chk(rcyc[ex][base[ex] % 256] == c0 + 2 + HL, "R2 hop latency",
          rcyc[ex][base[ex] % 256] - c0, 2 + HL);
    end

    // R3: arrival order preserved
    snap();
    for (int k = 0; k < 3; k++) begin
      put(1, mk(3 + k, 1, 1), 1'b1, 1'b1);
      tick();
    end
    repeat (6) tick();
    for (int k = 0; k < 3; k++)
      chk(tag_of(0, k) == 4'(3 + k), "R3 in-order delivery", int'(tag_of(0, k)), 3 + k);

    // R9: two outputs served in the same cycle
    snap();
    put(1, mk(6, 1, 1), 1'b1, 1'b1);
    put(0, mk(7, 3, 1), 1'b1, 1'b1);
    tick();
    repeat (6) tick();
    chk(rcnt[0] - base[0] == 1 && rcnt[3] - base[3] == 1, "R9 both delivered",
        (rcnt[0] - base[0]) + (rcnt[3] - base[3]), 2);
    chk(rcyc[0][base[0] % 256] == rcyc[3][base[3] % 256], "R9 same cycle",
        rcyc[0][base[0] % 256], rcyc[3][base[3] % 256]);

    // R6: two three-flit packets contending for the local output
    snap();
    put(3, mk(10, 1, 1), 1'b1, 1'b0); put(4, mk(11, 1, 1), 1'b1, 1'b0); tick();
    put(3, mk(10, 2, 2), 1'b0, 1'b0); put(4, mk(11, 0, 0), 1'b0, 1'b0); tick();
    put(3, mk(10, 3, 0), 1'b0, 1'b1); put(4, mk(11, 0, 3), 1'b0, 1'b1); tick();
    repeat (10) tick();
    chk(rcnt[0] - base[0] == 6, "R6 all flits delivered", rcnt[0] - base[0], 6);
    chk(tag_of(0, 0) == tag_of(0, 1) && tag_of(0, 1) == tag_of(0, 2),
        "R6 first packet unbroken", int'(tag_of(0, 1)), int'(tag_of(0, 0)));
    chk(tag_of(0, 3) == tag_of(0, 4) && tag_of(0, 4) == tag_of(0, 5)
        && tag_of(0, 3) != tag_of(0, 0),
        "R6 second packet unbroken", int'(tag_of(0, 4)), int'(tag_of(0, 3)));

    // R7: round-robin alternation between north and south
    snap();
    for (int k = 0; k < 2; k++) begin
      put(1, mk(1, 1, 1), 1'b1, 1'b1);
      put(2, mk(2, 1, 1), 1'b1, 1'b1);
      tick();
    end
    repeat (8) tick();
    chk(rcnt[0] - base[0] == 4, "R7 all delivered", rcnt[0] - base[0], 4);
    for (int k = 0; k < 3; k++)
      chk(tag_of(0, k) != tag_of(0, k + 1), "R7 grants alternate",
          int'(tag_of(0, k + 1)), int'(tag_of(0, k)) ^ 3);

    // R5 / R4: downstream credits run dry, then one is returned
    auto_en = 1'b0;
    repeat (2) tick();
    snap();
    for (int k = 0; k < DEP + 1; k++) begin
      put(1, mk(8, 1, 1), 1'b1, 1'b1);
      tick();
    end
    repeat (10) tick();
    t = rcnt[0] - base[0];
    chk(t == DEP, "R5 stall at zero credits", t, DEP);
    chk(ccnt[1] - cbase[1] == DEP, "R4 credits returned upstream", ccnt[1] - cbase[1], DEP);
    give_cr[0] = 1'b1;
    tick();
    give_cr[0] = 1'b0;
    repeat (6) tick();
    t = rcnt[0] - base[0];
    chk(t == DEP + 1, "R5 resume after credit", t, DEP + 1);
    chk(ccnt[1] - cbase[1] == DEP + 1, "R4 one credit per flit", ccnt[1] - cbase[1], DEP + 1);
    give_cr[0] = 1'b1;
    repeat (DEP) tick();
    give_cr[0] = 1'b0;
    auto_en = 1'b1;

    // local output usable again with restored credits
    snap();
    put(2, mk(9, 1, 1), 1'b1, 1'b1);
    tick();
    repeat (6) tick();
    chk(rcnt[0] - base[0] == 1, "R5 credits restored", rcnt[0] - base[0], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule